// File: doc/BRIEF.md
# Reversible-Cell Ripple Adder/Subtractor

This block adds or subtracts two unsigned operands with a carry (or borrow) input. It is combinational and has no clock. It is built only from reversible cells. Each cell has as many inputs as outputs, and the mapping from inputs to outputs is one-to-one. The block can sit in a datapath where information-lossless structure is wanted, or act as a reference for such a structure.

Each bit position holds one 4-in/4-out arithmetic cell. The cell takes the mode line, one bit of each operand and the incoming carry or borrow. It returns the result bit, the outgoing carry or borrow, and two garbage bits. The mode line switches the cell between full adder and full subtractor, so no operand inverter is needed. The carry or borrow ripples from bit 0 upward.

No cell output drives more than one destination. The mode line therefore reaches the cells through a chain of 2-in/2-out copy cells, each fed a constant zero. Every cell output that the result does not use appears on a garbage bus, so nothing is left undriven.

Top module: `rcell_addsub`

## Requirements
- R1: With `mode` = 0, `{cout, sum}` equals `a + b + cin` as a (W+1)-bit unsigned value.
- R2: With `mode` = 1, `sum` equals `(a - b - cin) mod 2^W`, and `cout` is 1 exactly when `a < b + cin`.
- R3: A carry or borrow entering at bit 0 ripples through every cell. For example, `a` = all ones, `b` = 0, `cin` = 1 in add mode gives `sum` = 0 and `cout` = 1. And `a` = 0, `b` = 0, `cin` = 1 in subtract mode gives `sum` = all ones and `cout` = 1.
- R4: The arithmetic cell is one-to-one. Its inputs are (m, x, y, ci) and its outputs are packed as {co, s, g1, g0}, with co in the top bit and g0 in bit 0. Its 16 input patterns give 16 distinct 4-bit outputs, and s and co are the full-adder sum and carry when m = 0, and the full-subtractor difference and borrow when m = 1.
- R5: The garbage bus `garb` has 2W+1 bits. Bit 2i carries `a[i]`, bit 2i+1 carries `mode ^ b[i]`, and bit 2W carries `mode`, which is the unused output of the last copy cell.
- R6: Widths follow the parameter W. The same structure gives correct add and subtract results for every input combination at W = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand (minuend in subtract mode) |
| b | input | W | Second operand (subtrahend in subtract mode) |
| mode | input | 1 | 0 = add, 1 = subtract |
| cin | input | 1 | Carry input (add) or borrow input (subtract) |
| sum | output | W | Sum or difference |
| cout | output | 1 | Carry output (add) or borrow output (subtract) |
| garb | output | 2W+1 | Unused cell outputs (garbage bus) |

## Verification
The bound checker holds at all times. It checks the arithmetic identity at the ports in both modes, and it checks that every garbage bit equals its operand-bit or mode relation. The checker cannot see bijectivity of the cell, because that property spans all input patterns rather than one. The bench therefore drives a standalone cell through all 16 patterns and compares every output pair. The bench also sweeps a 4-bit instance exhaustively and drives the long ripple cases on the 16-bit instance.

// File: rtl/rcell_pkg.sv
package rcell_pkg;

  typedef struct packed {
    logic co;
    logic s;
    logic g1;
    logic g0;
  } cell_o_t;

  // 4x4 one-to-one arithmetic cell: m selects add (0) or subtract (1).
  // Inverse: x = g0; y ^ ci = s ^ x; if y != ci then co reveals m, g1 reveals y;
  // if y == ci then co reveals y, g1 reveals m.
  function automatic cell_o_t cell_map(input logic m, input logic x,
                                       input logic y, input logic ci);
    cell_o_t r;
    r.g0 = x;
    r.g1 = m ^ y;
    r.s  = x ^ y ^ ci;
    r.co = ((m ^ x) & (y ^ ci)) | (y & ci);
    return r;
  endfunction

  // 2x2 copy cell: out[1] = x (forwarded), out[0] = x ^ y (copy when y = 0).
  function automatic logic [1:0] copy_map(input logic x, input logic y);
    return {x, x ^ y};
  endfunction

endpackage

// File: rtl/rcell_copy.sv
module rcell_copy (
  input  logic x,
  input  logic y,
  output logic xo,
  output logic yo
);
  import rcell_pkg::*;
  logic [1:0] res;
  assign res = copy_map(x, y);
  assign xo  = res[1];
  assign yo  = res[0];
endmodule

// File: rtl/rcell_arith.sv
module rcell_arith (
  input  logic m,
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic co,
  output logic s,
  output logic g1,
  output logic g0
);
  import rcell_pkg::*;
  cell_o_t res;
  assign res = cell_map(m, x, y, ci);
  assign co  = res.co;
  assign s   = res.s;
  assign g1  = res.g1;
  assign g0  = res.g0;
endmodule

// File: rtl/rcell_addsub.sv
module rcell_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         mode,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic [2*W:0] garb
);
  localparam int GTOP = 2 * W;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic m_src;
    logic m_fwd;
    logic m_cell;
    logic c_in;
    logic c_out;

    if (i == 0) begin : g_head
      assign m_src = mode;
      assign c_in  = cin;
    end else begin : g_link
      assign m_src = g_bit[i-1].m_fwd;
      assign c_in  = g_bit[i-1].c_out;
    end

    rcell_copy u_cp (
      .x  (m_src),
      .y  (1'b0),
      .xo (m_fwd),
      .yo (m_cell)
    );

    rcell_arith u_ar (
      .m  (m_cell),
      .x  (a[i]),
      .y  (b[i]),
      .ci (c_in),
      .co (c_out),
      .s  (sum[i]),
      .g1 (garb[2*i+1]),
      .g0 (garb[2*i])
    );
  end

  assign cout       = g_bit[W-1].c_out;
  assign garb[GTOP] = g_bit[W-1].m_fwd;

endmodule

// File: rtl/rcell_addsub_chk.sv
module rcell_addsub_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         mode,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic [2*W:0] garb
);
  logic [W:0] wide_add;
  logic [W:0] wide_sub;
  logic [W:0] ext_cin;

  assign ext_cin  = {{W{1'b0}}, cin};
  assign wide_add = {1'b0, a} + {1'b0, b} + ext_cin;
  assign wide_sub = {1'b0, a} - {1'b0, b} - ext_cin;

  always_comb begin
    if (!mode) begin
      p_add_r1: assert ({cout, sum} == wide_add)
        else $error("add identity broken");
    end else begin
      p_sub_r2: assert ({cout, sum} == wide_sub)
        else $error("subtract identity broken");
    end
    p_tail_mode_r5: assert (garb[2*W] == mode)
      else $error("tail copy does not carry mode");
    for (int i = 0; i < W; i++) begin
      p_garb_a_r5: assert (garb[2*i] == a[i])
        else $error("even garbage bit mismatch");
      p_garb_b_r5: assert (garb[2*i+1] == (mode ^ b[i]))
        else $error("odd garbage bit mismatch");
    end
  end
endmodule

bind rcell_addsub rcell_addsub_chk #(.W(W)) u_chk (
  .a(a), .b(b), .mode(mode), .cin(cin), .sum(sum), .cout(cout), .garb(garb)
);

// File: tb/sim_rcell_addsub.sv
module sim_rcell_addsub;
  localparam int WB = 16;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [WB-1:0] a0, b0, s0;
  logic          m0, c0, co0;
  logic [2*WB:0] g0;

  logic [WS-1:0] a1, b1, s1;
  logic          m1, c1, co1;
  logic [2*WS:0] g1;

  logic cm, cx, cy, cc;
  logic k_co, k_s, k_g1, k_g0;

  rcell_addsub #(.W(WB)) u0 (.a(a0), .b(b0), .mode(m0), .cin(c0),
                             .sum(s0), .cout(co0), .garb(g0));
  rcell_addsub #(.W(WS)) u1 (.a(a1), .b(b1), .mode(m1), .cin(c1),
                             .sum(s1), .cout(co1), .garb(g1));
  rcell_arith u_cell (.m(cm), .x(cx), .y(cy), .ci(cc),
                      .co(k_co), .s(k_s), .g1(k_g1), .g0(k_g0));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_garb(input int w, input longint a, input longint b, input bit m);
    logic [63:0] g = '0;
    for (int i = 0; i < w; i++) begin
      g[2*i]   = a[i];
      g[2*i+1] = b[i] ^ m;
    end
    g[2*w] = m;
    return g;
  endfunction

  // expected {cout,sum} computed with integers
  function automatic logic [63:0] exp_res(input int w, input longint a, input longint b,
                                          input bit m, input bit c);
    longint mask = (longint'(1) << w) - 1;
    longint r;
    bit     k;
    if (!m) begin
      r = a + b + c;
      k = (r > mask);
    end else begin
      r = a - b - c;
      k = (a < b + c);
    end
    return {63'(0), k} << w | 64'(r & mask);
  endfunction

  task automatic big(input string tag, input logic [WB-1:0] a, input logic [WB-1:0] b,
                     input bit m, input bit c);
    @(negedge clk);
    a0 = a; b0 = b; m0 = m; c0 = c;
    #1;
    chk(tag, {47'(0), co0, s0}, exp_res(WB, a, b, m, c));
    chk("R5 garbage (16-bit)", 64'(g0), exp_garb(WB, a, b, m));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] seen [16];
    a0 = '0; b0 = '0; m0 = 0; c0 = 0;
    a1 = '0; b1 = '0; m1 = 0; c1 = 0;
    cm = 0; cx = 0; cy = 0; cc = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle zero result", {47'(0), co0, s0}, 64'd0);
    chk("R5 idle zero garbage", 64'(g0), 64'd0);

    // R4: cell bijectivity and arithmetic, all 16 patterns
    for (int p = 0; p < 16; p++) begin
      int xv, yv, cv, tot;
      {cm, cx, cy, cc} = 4'(p);
      #1;
      seen[p] = {k_co, k_s, k_g1, k_g0};
      xv = cm ? int'(!cx) : int'(cx);
      yv = int'(cy); cv = int'(cc);
      tot = xv + yv + cv;
      chk("R4 cell sum/diff", 64'(k_s), 64'(cx ^ cy ^ cc));
      chk("R4 cell carry/borrow", 64'(k_co), 64'(tot >= 2));
    end
    for (int p = 0; p < 16; p++) begin
      for (int q = p + 1; q < 16; q++) begin
        checks++;
        if (seen[p] == seen[q]) begin
          errors++;
          $display("FAIL R4 cell not one-to-one actual=%h expected=distinct from %h", seen[q], seen[p]);
        end
      end
    end

    // R6: exhaustive sweep of the 4-bit instance (R1, R2 arithmetic)
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++) begin
            @(negedge clk);
            a1 = 4'(x); b1 = 4'(y); m1 = m[0]; c1 = c[0];
            #1;
            chk(m ? "R6 R2 4-bit subtract" : "R6 R1 4-bit add",
                {59'(0), co1, s1}, exp_res(WS, x, y, m[0], c[0]));
            chk("R5 4-bit garbage", 64'(g1), exp_garb(WS, x, y, m[0]));
          end

    // R3: full-length ripple corners
    big("R3 add ripple all ones +1", 16'hFFFF, 16'h0000, 0, 1);
    big("R3 sub ripple 0-0-1",       16'h0000, 16'h0000, 1, 1);
    big("R3 add max+max+1",          16'hFFFF, 16'hFFFF, 0, 1);
    big("R2 sub equal no borrow",    16'h5A5A, 16'h5A5A, 1, 0);
    big("R2 sub equal with borrow",  16'h5A5A, 16'h5A5A, 1, 1);
    big("R2 sub 0-FFFF",             16'h0000, 16'hFFFF, 1, 0);
    big("R1 add alternating",        16'hAAAA, 16'h5555, 0, 0);
    big("R1 add alternating carry",  16'hAAAA, 16'h5555, 0, 1);

    // R1 / R2: random 16-bit operands in both modes
    for (int n = 0; n < 300; n++) begin
      logic [WB-1:0] ra, rb;
      bit rc;
      ra = 16'($urandom); rb = 16'($urandom); rc = 1'($urandom);
      big("R1 random add", ra, rb, 0, rc);
      big("R2 random subtract", ra, rb, 1, rc);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule